// File: doc/BRIEF.md
# Offset-Reload Match Watchdog

This block is a watchdog built on a free-running 16-bit counter and a single compare channel. While the watchdog is active, an 8-bit compare byte is held against the counter's upper byte. The check is made only when the lower byte rolls over. A hit raises a one-cycle reset request. Software keeps the system alive by writing any value to the compare byte. That write does not store the data. It reloads the compare byte with the counter's present upper byte plus an 8-bit offset that software keeps in a separate register. The offset therefore sets how many upper-byte steps may pass between services.

The block comes up with the watchdog active. While active, it forces the counter to run and locks the counter bytes, the frozen configuration fields of the control register and the channel mode register against writes. Clearing the active bit releases every lock, and the compare byte then becomes a plain data register. Software reaches all state through a small register bus with a combinational read path. Counting is paced by an external clock-enable tick.

Top module: `match_watchdog`

## Requirements
- R1: After reset the control register (address 0) reads 0x80, with the active bit at bit 7 set and all other fields zero. The counter bytes (address 1 low, address 2 high), mode (address 3), compare (address 4) and offset (address 5) all read 0, and `wd_reset_o` is low.
- R2: The counter adds one on each cycle with `tick` high while it runs. The low byte wraps from 0xFF to 0x00 and carries one into the high byte.
- R3: The run request bit (control bit 6) reads back exactly as software last wrote it, so it reads 0 while the watchdog is active if software never set it. While the watchdog is active, the counter runs whatever that bit holds.
- R4: While active, a write of any data to address 4 loads the compare byte with (counter high byte + offset) mod 256, using the high byte as it was before that cycle's tick. While inactive, the same write stores the data.
- R5: `wd_reset_o` goes high for exactly one cycle. It rises in the cycle after a cycle in which the watchdog was active, `tick` advanced a low byte of 0xFF, and the incremented high byte equalled the compare byte.
- R6: After a service with offset N and low byte L, and with no further service, the request appears after (256 − L) + (N − 1)·256 ticks for N from 1 to 255. For N = 0 it appears after (256 − L) + 255·256 ticks.
- R7: While active, writes to both counter bytes, to the mode register, and to the source-select field (control bits 3:1) and idle-hold bit (control bit 0) have no effect.
- R8: Writing 0 to control bit 7 makes the watchdog inactive and releases every lock. The offset register accepts writes in any state.
- R9: The control register returns to 0x80 on the edge that raises `wd_reset_o`, and this takes priority over a control write in the same cycle.
- R10: If a service write to address 4 falls in the same cycle as a matching low-byte rollover, no reset request is raised, and the compare byte takes the reload value.
- R11: While inactive, no reset request is raised even on a matching rollover. With bit 6 clear as well, `tick` leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock-enable that paces the counter |
| bus_addr | input | ADDR_W | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Combinational read data of the selected register |
| wd_reset_o | output | 1 | One-cycle reset request |

## Verification
Two events can fall in the same clock edge: a service write to the compare byte and the low-byte rollover that would produce a match. The bench sets up this collision directly. With the watchdog inactive it loads the counter to one step before the match, then re-enables the watchdog and issues the service write together with the tick. It judges the outcome by the absence of the reset pulse, by a compare byte holding the pre-increment high byte plus the offset, and by the advanced counter. The random phase also lets services and ticks coincide freely near matches, and a bench-side model predicts the pulse on every cycle.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

   typedef enum logic [2:0] {
      REG_CTRL   = 3'd0,
      REG_CNT_LO = 3'd1,
      REG_CNT_HI = 3'd2,
      REG_MODE   = 3'd3,
      REG_CMP    = 3'd4,
      REG_OFFSET = 3'd5
   } reg_sel_e;

   typedef struct packed {
      logic       wd_on;
      logic       run_req;
      logic [1:0] spare;
      logic [2:0] src_sel;
      logic       idle_hold;
   } ctrl_t;

   localparam int    CTRL_W   = $bits(ctrl_t);
   localparam ctrl_t CTRL_RST = '{wd_on: 1'b1, run_req: 1'b0, spare: 2'b00,
                                  src_sel: 3'b000, idle_hold: 1'b0};

endpackage

// File: rtl/mwd_counter.sv
module mwd_counter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] lo_q,
   output logic [BYTE_W-1:0] hi_q,
   output logic [BYTE_W-1:0] hi_inc,
   output logic              lo_wrap
);
   localparam logic [BYTE_W-1:0] LO_TOP = '1;
   localparam logic [BYTE_W-1:0] ONE    = BYTE_W'(1);

   assign lo_wrap = step && (lo_q == LO_TOP);
   assign hi_inc  = hi_q + ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
      end else if (wr_lo) begin
         lo_q <= wdata;
      end else if (step) begin
         lo_q <= lo_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
      end else if (wr_hi) begin
         hi_q <= wdata;
      end else if (lo_wrap) begin
         hi_q <= hi_inc;
      end
   end
endmodule

// File: rtl/mwd_compare.sv
module mwd_compare #(
   parameter int BYTE_W       = 8,
   parameter bit SERVICE_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wd_on,
   input  logic              wr_cmp,
   input  logic              wr_off,
   input  logic              wr_mode,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [BYTE_W-1:0] cnt_hi,
   input  logic [BYTE_W-1:0] hi_inc,
   input  logic              lo_wrap,
   output logic [BYTE_W-1:0] cmp_q,
   output logic [BYTE_W-1:0] off_q,
   output logic [BYTE_W-1:0] mode_q,
   output logic              hit
);
   logic [BYTE_W-1:0] reload;
   logic              raw_hit;

   // 8-bit style adder, wraps modulo 2**BYTE_W
   assign reload  = cnt_hi + off_q;
   assign raw_hit = wd_on && lo_wrap && (hi_inc == cmp_q);

   generate
      if (SERVICE_WINS) begin : g_svc_wins
         assign hit = raw_hit && !wr_cmp;
      end else begin : g_match_wins
         assign hit = raw_hit;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (wr_cmp) begin
         cmp_q <= wd_on ? reload : wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= '0;
      end else if (wr_off) begin
         off_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (wr_mode && !wd_on) begin
         mode_q <= wdata;
      end
   end
endmodule

// File: rtl/mwd_ctrl.sv
module mwd_ctrl
   import mwd_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              hit,
   output ctrl_t             ctrl_q,
   output logic              rst_pulse
);
   ctrl_t img;

   assign img = ctrl_t'(wdata[CTRL_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
      end else if (hit) begin
         ctrl_q <= CTRL_RST;
      end else if (wr_ctrl) begin
         ctrl_q.wd_on   <= img.wd_on;
         ctrl_q.run_req <= img.run_req;
         if (!ctrl_q.wd_on) begin
            ctrl_q.src_sel   <= img.src_sel;
            ctrl_q.idle_hold <= img.idle_hold;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_pulse <= 1'b0;
      end else begin
         rst_pulse <= hit;
      end
   end
endmodule

// File: rtl/match_watchdog.sv
module match_watchdog
   import mwd_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter int ADDR_W       = 3,
   parameter bit SERVICE_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              wd_reset_o
);
   generate
      if (BYTE_W < CTRL_W) begin : g_bad_width
         $error("BYTE_W must hold the control register");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must decode six registers");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic              wd_on;
   logic              step;
   logic              sel_ctrl, sel_lo, sel_hi, sel_mode, sel_cmp, sel_off;
   logic [BYTE_W-1:0] cnt_lo, cnt_hi, hi_inc;
   logic              lo_wrap;
   logic [BYTE_W-1:0] cmp_q, off_q, mode_q;
   logic              hit;

   assign wd_on    = ctrl_q.wd_on;
   assign step     = tick && (wd_on || ctrl_q.run_req);
   assign sel_ctrl = bus_addr == ADDR_W'(REG_CTRL);
   assign sel_lo   = bus_addr == ADDR_W'(REG_CNT_LO);
   assign sel_hi   = bus_addr == ADDR_W'(REG_CNT_HI);
   assign sel_mode = bus_addr == ADDR_W'(REG_MODE);
   assign sel_cmp  = bus_addr == ADDR_W'(REG_CMP);
   assign sel_off  = bus_addr == ADDR_W'(REG_OFFSET);

   mwd_counter #(.BYTE_W(BYTE_W)) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .wr_lo  (bus_wr && sel_lo && !wd_on),
      .wr_hi  (bus_wr && sel_hi && !wd_on),
      .wdata  (bus_wdata),
      .lo_q   (cnt_lo),
      .hi_q   (cnt_hi),
      .hi_inc (hi_inc),
      .lo_wrap(lo_wrap)
   );

   mwd_compare #(.BYTE_W(BYTE_W), .SERVICE_WINS(SERVICE_WINS)) cmp_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wd_on  (wd_on),
      .wr_cmp (bus_wr && sel_cmp),
      .wr_off (bus_wr && sel_off),
      .wr_mode(bus_wr && sel_mode),
      .wdata  (bus_wdata),
      .cnt_hi (cnt_hi),
      .hi_inc (hi_inc),
      .lo_wrap(lo_wrap),
      .cmp_q  (cmp_q),
      .off_q  (off_q),
      .mode_q (mode_q),
      .hit    (hit)
   );

   mwd_ctrl #(.BYTE_W(BYTE_W)) ctl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (bus_wr && sel_ctrl),
      .wdata    (bus_wdata),
      .hit      (hit),
      .ctrl_q   (ctrl_q),
      .rst_pulse(wd_reset_o)
   );

   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl)      bus_rdata = BYTE_W'(ctrl_q);
      else if (sel_lo)   bus_rdata = cnt_lo;
      else if (sel_hi)   bus_rdata = cnt_hi;
      else if (sel_mode) bus_rdata = mode_q;
      else if (sel_cmp)  bus_rdata = cmp_q;
      else if (sel_off)  bus_rdata = off_q;
   end
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker
   import mwd_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic              wd_reset_o,
   input ctrl_t             ctrl_q,
   input logic [BYTE_W-1:0] cnt_lo,
   input logic [BYTE_W-1:0] cnt_hi,
   input logic [BYTE_W-1:0] cmp_q,
   input logic [BYTE_W-1:0] off_q,
   input logic [BYTE_W-1:0] mode_q
);
   localparam int CW = 2 * BYTE_W;
   logic [CW-1:0] cnt;
   assign cnt = {cnt_hi, cnt_lo};

   // R5: request is a single-cycle pulse
   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wd_reset_o |=> !wd_reset_o);

   // R5: a pulse follows an active rollover of the low byte
   assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_reset_o) |-> $past(ctrl_q.wd_on && tick && (cnt_lo == '1)));

   // R9: control returns to its reset image with the pulse
   assert_ctrl_default_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wd_reset_o |-> (ctrl_q == CTRL_RST));

   // R7: locked counter writes only let the count advance
   assert_cnt_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.wd_on && bus_wr && (bus_addr == ADDR_W'(REG_CNT_LO) ||
                                  bus_addr == ADDR_W'(REG_CNT_HI)))
      |=> cnt == $past(cnt) + CW'($past(tick)));

   // R3: counter forced to run while active
   assert_run_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.wd_on && tick) |=> cnt == $past(cnt) + CW'(1));

   // R7: mode register blocked while active
   assert_mode_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.wd_on && bus_wr && bus_addr == ADDR_W'(REG_MODE)) |=> $stable(mode_q));

   // R4: service reload from the pre-tick high byte plus offset
   assert_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.wd_on && bus_wr && bus_addr == ADDR_W'(REG_CMP))
      |=> cmp_q == $past(BYTE_W'(cnt_hi + off_q)));

   // R8: offset always writable
   assert_off_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(REG_OFFSET)) |=> off_q == $past(bus_wdata));
endmodule

bind match_watchdog mwd_checker #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .wd_reset_o(wd_reset_o),
   .ctrl_q    (ctrl_q),
   .cnt_lo    (cnt_lo),
   .cnt_hi    (cnt_hi),
   .cmp_q     (cmp_q),
   .off_q     (off_q),
   .mode_q    (mode_q)
);

// File: tb/match_watchdog_tb_top.sv
module match_watchdog_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       wd_reset_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] m_lo, m_hi, m_cmp, m_off, m_mode;
   logic       m_wd, m_run, m_idle;
   logic [2:0] m_sel;

   always #4 clk = ~clk;

   match_watchdog dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wd_reset_o(wd_reset_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_ctrl();
      return {m_wd, m_run, 2'b00, m_sel, m_idle};
   endfunction

   function automatic int steps_to_fire(input logic [7:0] lo, input logic [7:0] off);
      int n;
      n = (off == 8'd0) ? 256 : int'(off);
      return (256 - int'(lo)) + (n - 1) * 256;
   endfunction

   task automatic model_reset();
      m_lo = 0; m_hi = 0; m_cmp = 0; m_off = 0; m_mode = 0;
      m_wd = 1'b1; m_run = 1'b0; m_sel = 3'd0; m_idle = 1'b0;
   endtask

   // one clock cycle of stimulus, model update and pulse check
   task automatic cyc(input bit t, input bit w, input logic [2:0] a, input logic [7:0] d);
      bit inc, svc, p;
      logic [7:0] lo_n, hi_n, cmp_n, off_n, mode_n;
      logic wd_n, run_n, idle_n;
      logic [2:0] sel_n;
      inc = t && (m_wd || m_run);
      svc = w && (a == 3'd4);
      p = m_wd && inc && (m_lo == 8'hFF) && (8'(m_hi + 8'd1) == m_cmp) && !svc;
      lo_n = m_lo; hi_n = m_hi; cmp_n = m_cmp; off_n = m_off; mode_n = m_mode;
      wd_n = m_wd; run_n = m_run; sel_n = m_sel; idle_n = m_idle;
      if (w && a == 3'd1 && !m_wd) lo_n = d;
      else if (inc) lo_n = m_lo + 8'd1;
      if (w && a == 3'd2 && !m_wd) hi_n = d;
      else if (inc && m_lo == 8'hFF) hi_n = m_hi + 8'd1;
      if (svc) cmp_n = m_wd ? 8'(m_hi + m_off) : d;
      if (w && a == 3'd5) off_n = d;
      if (w && a == 3'd3 && !m_wd) mode_n = d;
      if (p) begin
         wd_n = 1'b1; run_n = 1'b0; sel_n = 3'd0; idle_n = 1'b0;
      end else if (w && a == 3'd0) begin
         wd_n = d[7]; run_n = d[6];
         if (!m_wd) begin sel_n = d[3:1]; idle_n = d[0]; end
      end
      tick = t; bus_wr = w; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0; bus_wr = 1'b0;
      m_lo = lo_n; m_hi = hi_n; m_cmp = cmp_n; m_off = off_n; m_mode = mode_n;
      m_wd = wd_n; m_run = run_n; m_sel = sel_n; m_idle = idle_n;
      check("R5 pulse per cycle", 32'(wd_reset_o), 32'(p));
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
      bus_addr = a; bus_wr = 1'b0;
      #1;
      check(tag, 32'(bus_rdata), 32'(exp));
   endtask

   task automatic rd_all(input string tag);
      rd(3'd0, m_ctrl(), tag);
      rd(3'd1, m_lo, tag);
      rd(3'd2, m_hi, tag);
      rd(3'd3, m_mode, tag);
      rd(3'd4, m_cmp, tag);
      rd(3'd5, m_off, tag);
   endtask

   task automatic run_timeout(input logic [7:0] off);
      int cnt, exp;
      cyc(0, 1, 3'd5, off);
      cyc(0, 1, 3'd4, 8'h5A);
      exp = steps_to_fire(m_lo, off);
      cnt = 0;
      while (cnt < 70000) begin
         cyc(1, 0, 3'd0, 8'd0);
         cnt++;
         if (wd_reset_o) break;
      end
      check("R6 timeout steps", 32'(cnt), 32'(exp));
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'h00C0FFEE);
      model_reset();
      repeat (3) @(negedge clk);
      rd_all("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      rd_all("R1 after reset");
      check("R1 no request", 32'(wd_reset_o), 32'd0);

      // R2 / R3: counter runs with run request clear
      repeat (5) cyc(1, 0, 3'd0, 8'd0);
      rd(3'd1, 8'd5, "R2 count");
      rd(3'd0, 8'h80, "R3 run bit reads zero");
      cyc(0, 1, 3'd0, 8'h80);
      cyc(1, 0, 3'd0, 8'd0);
      rd(3'd1, 8'd6, "R3 forced run");
      cyc(0, 1, 3'd0, 8'hC0);
      rd(3'd0, 8'hC0, "R3 run bit readback");
      cyc(0, 1, 3'd0, 8'h80);

      // R7: locked writes
      cyc(0, 1, 3'd1, 8'h55);
      cyc(0, 1, 3'd2, 8'h66);
      cyc(0, 1, 3'd3, 8'h3C);
      cyc(0, 1, 3'd0, 8'h8F);
      rd(3'd0, 8'h80, "R7 frozen fields");
      rd(3'd3, 8'h00, "R7 mode blocked");
      rd(3'd1, 8'd6, "R7 low byte kept");
      rd_all("R7 locked state");

      // R4: service reload
      cyc(0, 1, 3'd5, 8'h10);
      cyc(0, 1, 3'd4, 8'hAB);
      rd(3'd4, 8'h10, "R4 reload value");

      // R8: release locks
      cyc(0, 1, 3'd0, 8'h40);
      cyc(0, 1, 3'd1, 8'h12);
      cyc(0, 1, 3'd2, 8'h34);
      cyc(0, 1, 3'd3, 8'h3C);
      cyc(0, 1, 3'd0, 8'h4F);
      rd(3'd1, 8'h12, "R8 counter writable");
      rd(3'd0, 8'h4F, "R8 fields writable");
      rd_all("R8 released state");
      cyc(0, 1, 3'd4, 8'h77);
      rd(3'd4, 8'h77, "R4 plain store when inactive");

      // R11: inactive, matching rollover, no request
      cyc(0, 1, 3'd1, 8'hFF);
      cyc(0, 1, 3'd2, 8'h76);
      cyc(1, 0, 3'd0, 8'd0);
      check("R11 no request inactive", 32'(wd_reset_o), 32'd0);
      rd(3'd2, 8'h77, "R2 carry into high byte");
      cyc(0, 1, 3'd0, 8'h00);
      cyc(1, 0, 3'd0, 8'd0);
      rd(3'd1, 8'h00, "R11 stopped low");
      rd(3'd2, 8'h77, "R11 stopped high");

      // R10: service collides with matching rollover
      cyc(0, 1, 3'd1, 8'hFF);
      cyc(0, 1, 3'd2, 8'h20);
      cyc(0, 1, 3'd5, 8'h05);
      cyc(0, 1, 3'd4, 8'h21);
      cyc(0, 1, 3'd0, 8'h80);
      cyc(1, 1, 3'd4, 8'h99);
      check("R10 no request on collision", 32'(wd_reset_o), 32'd0);
      rd(3'd4, 8'h25, "R10 reload from pre-tick byte");
      rd(3'd2, 8'h21, "R10 high byte");
      rd(3'd1, 8'h00, "R10 low byte");

      // R5 / R9: plain match with non-default control image
      cyc(0, 1, 3'd0, 8'h00);
      cyc(0, 1, 3'd1, 8'hFF);
      cyc(0, 1, 3'd2, 8'h21);
      cyc(0, 1, 3'd4, 8'h22);
      cyc(0, 1, 3'd0, 8'hCE);
      rd(3'd0, 8'hCE, "R9 image before match");
      cyc(1, 0, 3'd0, 8'd0);
      check("R5 request raised", 32'(wd_reset_o), 32'd1);
      rd(3'd0, 8'h80, "R9 control restored");
      cyc(0, 0, 3'd0, 8'd0);
      check("R5 request one cycle", 32'(wd_reset_o), 32'd0);

      // R6: timeout length
      run_timeout(8'd3);
      run_timeout(8'd1);
      run_timeout(8'd0);

      // random phase with servicing and locked writes
      cyc(0, 1, 3'd5, 8'd2);
      for (int i = 0; i < 9000; i++) begin
         int r;
         bit t;
         r = int'($urandom % 100);
         t = ($urandom % 4) != 0;
         if (r < 2) cyc(t, 1, 3'd4, 8'($urandom));
         else if (r < 5) cyc(t, 1, 3'(1 + $urandom % 3), 8'($urandom));
         else if (r < 6) cyc(t, 1, 3'd0, {1'b1, 7'($urandom)});
         else if (r < 7) cyc(t, 1, 3'd5, 8'(1 + $urandom % 3));
         else cyc(t, 0, 3'd0, 8'd0);
         if ((i % 64) == 63) rd_all("R7 random locked state");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule